// File: doc/BRIEF.md
# Interrupt Code Transmit Scheduler

The scheduler takes requests to send 8-bit interrupt or acknowledge codes from two sources and forwards each one to the link transmitter. One source is a register write strobe that carries an issue bit and a code field. The other is a level request/done handshake with its own 8-bit code bus. The block chooses between the two sources and accepts one code only while the transmit-enable input is high. It then holds that code until the delay timer for its interrupt number reports expiry, and only then raises a one-cycle send strobe that carries the code.

The interrupt number is bits 4:0 of the code. It selects one bit of a 32-bit timer-expired vector. Bits 7:5 of the code pass through to the transmitter unchanged. The block holds only one code at a time. Until the held code has been sent, no other request is taken.

Top module: `int_code_tx_sched`

## Requirements
- R1: After reset, `send_o` and `raw_done_o` are 0 and no code is held.
- R2: At a clock edge, a write is accepted when all of the following are true: `reg_wr_i`=1, `reg_issue_i`=1, `tx_en_i`=1 and no code is held. The code on `reg_code_i` is then held. A write with `reg_issue_i`=0 is ignored.
- R3: At a clock edge, a raw request is accepted when all of the following are true: `raw_req_i`=1, `tx_en_i`=1, no code is held, `raw_done_o`=0 and no register write is accepted at that edge. `raw_done_o` goes to 1 in the cycle after acceptance. It stays at 1 while `raw_req_i` stays at 1. It returns to 0 one cycle after `raw_req_i` falls.
- R4: While `tx_en_i`=0, no request is accepted. A register write in that state is lost. A raw request waits with `raw_done_o`=0. A held code is not sent until `tx_en_i` returns to 1.
- R5: A held code is sent only at a clock edge where `tmr_expired_i[code[4:0]]`=1. `send_o` is high in the cycle that follows that edge. Expiry bits for other numbers have no effect.
- R6: When a register write and a raw request are both valid at the same edge, the register code is taken. The raw request keeps waiting with `raw_done_o`=0, and it is accepted after the register code has been sent.
- R7: While a code is held, register writes are lost and raw requests wait. The held code does not change.
- R8: `send_o` is a single-cycle pulse. While it is high, `send_code_o` equals the accepted 8-bit code, bits 7:5 included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable for both sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_issue_i | input | 1 | Issue bit of the register write |
| reg_code_i | input | 8 | Code field of the register write |
| raw_req_i | input | 1 | Raw path request level |
| raw_code_i | input | 8 | Raw path code |
| raw_done_o | output | 1 | Raw path acceptance indication |
| tmr_expired_i | input | 32 | Per-number delay timer expired flags |
| send_o | output | 1 | One-cycle send strobe to the transmitter |
| send_code_o | output | 8 | Code to transmit, valid with send_o |

## Verification
A register write and a raw request can arrive in the same cycle and compete for the single holding slot. The bench raises both on the same edge with every expiry bit set. It then checks three things in order: that the register code comes out first, that `raw_done_o` stays low while the register code is held and sent, and that the raw code is accepted and sent afterwards. A second collision occurs when a register write arrives during a pending send. The bench judges that case by showing that only the original code leaves the block and that no second send follows.

// File: rtl/int_code_tx_pkg.sv
package int_code_tx_pkg;
  localparam int unsigned ICT_CODE_W = 8;
  localparam int unsigned ICT_NUM_W  = 5;

  function automatic logic [ICT_NUM_W-1:0] code_num(input logic [ICT_CODE_W-1:0] code);
    return code[ICT_NUM_W-1:0];
  endfunction
endpackage

// File: rtl/ict_src_arbiter.sv
module ict_src_arbiter #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              idle_i,
  input  logic              reg_wr_i,
  input  logic              reg_issue_i,
  input  logic [CODE_W-1:0] reg_code_i,
  input  logic              raw_req_i,
  input  logic [CODE_W-1:0] raw_code_i,
  output logic              take_o,
  output logic [CODE_W-1:0] take_code_o,
  output logic              raw_done_o
);
  logic reg_take, raw_take, done_q;

  assign reg_take = idle_i && tx_en_i && reg_wr_i && reg_issue_i;
  // register path has priority; raw waits with done low
  assign raw_take = idle_i && tx_en_i && raw_req_i && !done_q && !reg_take;

  assign take_o      = reg_take || raw_take;
  assign take_code_o = reg_take ? reg_code_i : raw_code_i;
  assign raw_done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  done_q <= 1'b0;
    else if (raw_take)            done_q <= 1'b1;
    else if (done_q && !raw_req_i) done_q <= 1'b0;
  end

  p_done_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(raw_req_i && tx_en_i && idle_i));
  p_done_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && raw_req_i) |=> done_q);
  p_reg_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_issue_i && idle_i && tx_en_i) |=> !$rose(done_q));
  p_no_take_dis_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !$rose(done_q));
endmodule

// File: rtl/ict_expiry_sel.sv
module ict_expiry_sel #(
  parameter int unsigned NUM_W = 5
) (
  input  logic [NUM_W-1:0]      num_i,
  input  logic [(1<<NUM_W)-1:0] tmr_i,
  output logic                  expired_o
);
  localparam int unsigned NUM_INT = 1 << NUM_W;
  logic [NUM_INT-1:0] hit;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_hit
    assign hit[i] = tmr_i[i] && (num_i == NUM_W'(i));
  end

  assign expired_o = |hit;
endmodule

// File: rtl/ict_send_stage.sv
module ict_send_stage #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned NUM_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              take_i,
  input  logic [CODE_W-1:0] take_code_i,
  input  logic              sel_expired_i,
  output logic              busy_o,
  output logic [NUM_W-1:0]  num_o,
  output logic              send_o,
  output logic [CODE_W-1:0] send_code_o
);
  logic              busy_q, send_q, fire;
  logic [CODE_W-1:0] code_q;

  assign fire = busy_q && tx_en_i && sel_expired_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      send_q <= 1'b0;
      code_q <= '0;
    end else begin
      send_q <= fire;
      if (fire)        busy_q <= 1'b0;
      else if (take_i) begin
        busy_q <= 1'b1;
        code_q <= take_code_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign num_o       = code_q[NUM_W-1:0];
  assign send_o      = send_q;
  assign send_code_o = code_q;

  p_send_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_q |=> !send_q);
  p_send_expired_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_q) |-> $past(sel_expired_i));
  p_send_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_q) |-> $past(tx_en_i));
  p_code_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fire) |=> $stable(code_q));
endmodule

// File: rtl/int_code_tx_sched.sv
module int_code_tx_sched
  import int_code_tx_pkg::*;
#(
  parameter int unsigned CODE_W = ICT_CODE_W,
  parameter int unsigned NUM_W  = ICT_NUM_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tx_en_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_issue_i,
  input  logic [CODE_W-1:0]     reg_code_i,
  input  logic                  raw_req_i,
  input  logic [CODE_W-1:0]     raw_code_i,
  output logic                  raw_done_o,
  input  logic [(1<<NUM_W)-1:0] tmr_expired_i,
  output logic                  send_o,
  output logic [CODE_W-1:0]     send_code_o
);
  logic              busy, take, sel_expired;
  logic [CODE_W-1:0] take_code;
  logic [NUM_W-1:0]  num;

  ict_src_arbiter #(.CODE_W(CODE_W)) u_arb (
    .clk_i, .rst_ni, .tx_en_i,
    .idle_i(!busy),
    .reg_wr_i, .reg_issue_i, .reg_code_i,
    .raw_req_i, .raw_code_i,
    .take_o(take), .take_code_o(take_code),
    .raw_done_o
  );

  ict_expiry_sel #(.NUM_W(NUM_W)) u_sel (
    .num_i(num), .tmr_i(tmr_expired_i), .expired_o(sel_expired)
  );

  ict_send_stage #(.CODE_W(CODE_W), .NUM_W(NUM_W)) u_send (
    .clk_i, .rst_ni, .tx_en_i,
    .take_i(take), .take_code_i(take_code),
    .sel_expired_i(sel_expired),
    .busy_o(busy), .num_o(num),
    .send_o, .send_code_o
  );

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_o) |-> $past(busy));
endmodule

// File: tb/int_code_tx_sched_test.sv
module int_code_tx_sched_test;
  logic clk = 0, rst_n = 0;
  logic tx_en = 0, reg_wr = 0, reg_issue = 0, raw_req = 0;
  logic [7:0] reg_code = 0, raw_code = 0;
  logic [31:0] tmr = 0;
  logic raw_done, send;
  logic [7:0] send_code;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  int_code_tx_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en),
    .reg_wr_i(reg_wr), .reg_issue_i(reg_issue), .reg_code_i(reg_code),
    .raw_req_i(raw_req), .raw_code_i(raw_code), .raw_done_o(raw_done),
    .tmr_expired_i(tmr), .send_o(send), .send_code_o(send_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] others(input logic [7:0] c);
    return ~(32'(1) << c[4:0]);
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic reg_send(input logic [7:0] c, input int wait_n);
    step(); reg_wr = 1; reg_issue = 1; reg_code = c; tmr = others(c);
    step(); reg_wr = 0;
    for (int k = 0; k < wait_n; k++) begin
      chk("R5 no send before own expiry", 32'(send), 0);
      step();
    end
    tmr = 32'(1) << c[4:0];
    step(); chk("R2 reg send", 32'(send), 1); chk("R8 reg code", 32'(send_code), 32'(c));
    tmr = 0;
    step(); chk("R8 single pulse", 32'(send), 0);
  endtask

  task automatic raw_send(input logic [7:0] c);
    step(); raw_req = 1; raw_code = c; tmr = others(c);
    step(); chk("R3 done high", 32'(raw_done), 1); raw_req = 0; raw_code = 8'hxx;
    step(); chk("R3 done low", 32'(raw_done), 0); chk("R5 raw wait", 32'(send), 0);
    tmr = 32'(1) << c[4:0];
    step(); chk("R5 raw send", 32'(send), 1); chk("R8 raw code", 32'(send_code), 32'(c));
    tmr = 0;
    step(); chk("R8 raw pulse", 32'(send), 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 send reset", 32'(send), 0);
    chk("R1 done reset", 32'(raw_done), 0);
    rst_n = 1; tx_en = 1;
    step();
    chk("R1 idle after reset", 32'(send), 0);

    // sweep all numbers and upper bit patterns on both paths
    for (int n = 0; n < 32; n++) begin
      reg_send(8'((n % 8) << 5 | n), n % 3);
      raw_send(8'(((n + 3) % 8) << 5 | n));
    end

    // R2: issue bit clear ignored
    step(); reg_wr = 1; reg_issue = 0; reg_code = 8'h05; tmr = '1;
    step(); reg_wr = 0;
    for (int k = 0; k < 3; k++) begin step(); chk("R2 issue=0 ignored", 32'(send), 0); end
    tmr = 0;

    // R4: disabled write lost
    tx_en = 0; reg_wr = 1; reg_issue = 1; reg_code = 8'h07;
    step(); reg_wr = 0; tx_en = 1; tmr = '1;
    for (int k = 0; k < 3; k++) begin step(); chk("R4 disabled write lost", 32'(send), 0); end
    tmr = 0;

    // R4: raw waits while disabled
    tx_en = 0; raw_req = 1; raw_code = 8'h2a;
    for (int k = 0; k < 3; k++) begin step(); chk("R4 raw waits disabled", 32'(raw_done), 0); end
    tx_en = 1;
    step(); chk("R4 raw accepted on enable", 32'(raw_done), 1); raw_req = 0;
    // R4: held code not sent while disabled
    tx_en = 0; tmr = '1;
    for (int k = 0; k < 3; k++) begin step(); chk("R4 held not sent", 32'(send), 0); end
    tx_en = 1;
    step(); chk("R4 sent on enable", 32'(send), 1); chk("R8 code", 32'(send_code), 32'h2a);
    tmr = 0;
    step(); chk("R8 pulse", 32'(send), 0);

    // R6: simultaneous requests
    reg_wr = 1; reg_issue = 1; reg_code = 8'h61; raw_req = 1; raw_code = 8'h92; tmr = '1;
    step(); reg_wr = 0; chk("R6 raw waits", 32'(raw_done), 0);
    step(); chk("R6 reg first", 32'(send), 1); chk("R6 reg code", 32'(send_code), 32'h61);
    chk("R6 done still low", 32'(raw_done), 0);
    step(); chk("R6 raw accepted after", 32'(raw_done), 1); raw_req = 0;
    step(); chk("R6 raw sent", 32'(send), 1); chk("R6 raw code", 32'(send_code), 32'h92);
    tmr = 0;
    step(); chk("R6 done drops", 32'(raw_done), 0);

    // R7: write during pending is lost, held code unchanged
    reg_wr = 1; reg_issue = 1; reg_code = 8'h03;
    step(); reg_code = 8'h04;
    step(); reg_wr = 0; chk("R7 no send yet", 32'(send), 0);
    raw_req = 1; raw_code = 8'h08;
    step(); chk("R7 raw waits busy", 32'(raw_done), 0);
    raw_req = 0;
    tmr = 32'h0000_0010;
    for (int k = 0; k < 2; k++) begin step(); chk("R7 other expiry ignored", 32'(send), 0); end
    tmr = 32'h0000_0008;
    step(); chk("R7 original sent", 32'(send), 1); chk("R7 original code", 32'(send_code), 32'h03);
    tmr = '1;
    for (int k = 0; k < 3; k++) begin step(); chk("R7 no second send", 32'(send), 0); end
    tmr = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule